// File: doc/BRIEF.md
# Sample-and-hold refresh sequencer

This controller keeps a bank of 32 held analog levels alive. It owns a code memory with one 16-bit converter code per channel. It walks that memory in an endless loop. For each channel it reads the stored code, presents it to a shared converter, waits for the converter to settle, and then pulses that channel's hold strobe for one system clock. The steps advance on a sequencer tick. The tick is either an internal divided pulse or an external clock-enable, and the choice is made at an input pin.

A serial front end, which is not part of this block, hands over decoded writes: a channel address, a 16-bit code and the chip-select level. While chip-select is active the scan is frozen, although the channel already in flight is finished. Writes go straight into memory. In immediate mode, the last channel written is serviced first once chip-select drops, and the scan then picks up again at the address where it was interrupted. With immediate mode off (burst loading), several channels can be written in one window, and they are refreshed by the normal scan after it resumes.

Top module: `sah_refresh_seq`

## Requirements
- R1: While reset is high and on the cycle after it, `hold_strobe` is all zero and `dac_code` is zero. The first channel the scan refreshes after reset is channel 0.
- R2: Each channel refresh takes exactly 4 sequencer ticks. With a tick on every clock, strobes in an unbroken scan are exactly 4 clocks apart. At the strobe, `dac_code` equals the code held in memory for the strobed channel, and `dac_code` changes only on the second tick of a refresh.
- R3: Without chip-select activity, channels are refreshed in ascending order 0,1,…,31 and the order then wraps to 0. A full sweep takes 128 ticks.
- R4: `hold_strobe` is one-hot or zero, with bit k strobing channel k, and every pulse lasts exactly one clock.
- R5: When `tick_ext_sel` is 0, a tick occurs every `TICK_DIV` clocks, so strobes are 4·`TICK_DIV` clocks apart. When it is 1, a tick occurs on each clock where `tick_ext_en` is 1, so strobes are 4 enabled clocks apart.
- R6: While `cs_active` is 1, no new channel refresh starts. A refresh already started when chip-select rose runs to its strobe.
- R7: A write (`wr_en` = 1) stores `wr_code` at `wr_addr` in the same cycle. Every later refresh of that channel uses the new code.
- R8: Immediate mode is `imm_pin` OR `imm_cfg`, taken in the cycle of the write. When a write is made in immediate mode, the channel written last is the first one strobed after `cs_active` falls, with its new code, no more than 8 ticks after the release.
- R9: After the immediate channel, the scan resumes at the interrupted address and continues upward. The interrupted address is the channel in flight when chip-select rose, or, if no channel was in flight, the channel that was due next.
- R10: In burst loading (immediate mode 0 for every write), no channel gets priority. The first strobe after release is the interrupted address. All 32 channels carry their current codes within the 33 strobes that follow the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ext_sel | input | 1 | 1: the external enable is the tick; 0: the internal divider is the tick |
| tick_ext_en | input | 1 | External sequencer clock-enable |
| cs_active | input | 1 | Chip-select level from the serial front end, active high |
| wr_en | input | 1 | Decoded write strobe |
| wr_addr | input | AW (5) | Channel address of the write |
| wr_code | input | CODE_W (16) | Converter code of the write |
| imm_pin | input | 1 | External immediate-mode pin |
| imm_cfg | input | 1 | Immediate-mode control bit from the serial word |
| dac_code | output | CODE_W (16) | Code presented to the shared converter |
| hold_strobe | output | NUM_CH (32) | One-hot hold strobe, one bit per channel |

## Verification
The assertions assume that `wr_en` is raised only while `cs_active` is 1. They also assume that `imm_pin` and `imm_cfg` are steady during the write cycle they qualify. The bench drives writes only inside chip-select windows it has already opened. It holds each window at least 10 clocks, so that any refresh in flight finishes before release. It changes the mode inputs only on the falling clock edge. Random rounds pick the mode, the window start, and the write addresses and codes from a seeded generator. Directed cases set up the in-flight and idle interrupt points.

// File: rtl/sah_seq_pkg.sv
package sah_seq_pkg;
  // Sub-steps of one channel refresh; PH_IDLE is also the slot-start decision.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DRIVE  = 2'd1,
    PH_SETTLE = 2'd2,
    PH_STROBE = 2'd3
  } phase_t;
endpackage

// File: rtl/sah_tick_gen.sv
module sah_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_sel,
  input  logic ext_en,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_cnt;
  logic          div_tick;

  assign div_tick = (div_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)           div_cnt <= '0;
    else if (div_tick) div_cnt <= '0;
    else               div_cnt <= div_cnt + 1'b1;
  end

  assign tick = ext_sel ? ext_en : div_tick;
endmodule

// File: rtl/sah_code_mem.sv
module sah_code_mem #(
  parameter int DEPTH = 32,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] store [DEPTH];

  // Single clock, one write port, one registered read port (read-first).
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/sah_scan_ctrl.sv
module sah_scan_ctrl
  import sah_seq_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int AW    = $clog2(NUM_CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          cs_active,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          imm_mode,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          load_code,
  output logic          strobe_en,
  output logic [AW-1:0] strobe_ch,
  output phase_t        phase
);
  logic [AW-1:0] scan_ptr, cur_ch, pend_ch, resume_ptr, start_ch;
  logic          pend, intr, cs_q, cs_rise, busy, start;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
    return (a == AW'(NUM_CH - 1)) ? '0 : a + 1'b1;
  endfunction

  assign busy     = (phase != PH_IDLE);
  assign cs_rise  = cs_active & ~cs_q;
  assign start    = tick & ~busy & ~cs_active;
  assign start_ch = pend ? pend_ch : (intr ? resume_ptr : scan_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      scan_ptr   <= '0;
      cur_ch     <= '0;
      pend       <= 1'b0;
      pend_ch    <= '0;
      intr       <= 1'b0;
      resume_ptr <= '0;
      cs_q       <= 1'b0;
    end else begin
      cs_q <= cs_active;
      // Capture the interrupted address once per outstanding interruption.
      if (cs_rise && !intr) begin
        intr       <= 1'b1;
        resume_ptr <= busy ? cur_ch : scan_ptr;
      end
      if (tick) begin
        unique case (phase)
          PH_IDLE: if (!cs_active) begin
            phase  <= PH_DRIVE;
            cur_ch <= start_ch;
            if (pend) begin
              pend <= 1'b0;
            end else if (intr) begin
              intr     <= 1'b0;
              scan_ptr <= wrap_inc(resume_ptr);
            end else begin
              scan_ptr <= wrap_inc(scan_ptr);
            end
          end
          PH_DRIVE:  phase <= PH_SETTLE;
          PH_SETTLE: phase <= PH_STROBE;
          PH_STROBE: phase <= PH_IDLE;
          default:   phase <= PH_IDLE;
        endcase
      end
      // A new immediate write overrides any earlier pending channel.
      if (wr_en && imm_mode) begin
        pend    <= 1'b1;
        pend_ch <= wr_addr;
      end
    end
  end

  assign rd_en     = start;
  assign rd_addr   = start_ch;
  assign load_code = tick & (phase == PH_DRIVE);
  assign strobe_en = tick & (phase == PH_STROBE);
  assign strobe_ch = cur_ch;
endmodule

// File: rtl/sah_refresh_seq.sv
module sah_refresh_seq
  import sah_seq_pkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int CODE_W   = 16,
  parameter int TICK_DIV = 4,
  localparam int AW      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ext_sel,
  input  logic              tick_ext_en,
  input  logic              cs_active,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              imm_pin,
  input  logic              imm_cfg,
  output logic [CODE_W-1:0] dac_code,
  output logic [NUM_CH-1:0] hold_strobe
);
  logic              tick;
  logic              rd_en, load_code, strobe_en;
  logic [AW-1:0]     rd_addr, strobe_ch;
  logic [CODE_W-1:0] rd_data;
  phase_t            phase;

  sah_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .ext_sel(tick_ext_sel), .ext_en(tick_ext_en), .tick(tick)
  );

  sah_code_mem #(.DEPTH(NUM_CH), .W(CODE_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_code),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  sah_scan_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .cs_active(cs_active),
    .wr_en(wr_en), .wr_addr(wr_addr), .imm_mode(imm_pin | imm_cfg),
    .rd_en(rd_en), .rd_addr(rd_addr), .load_code(load_code),
    .strobe_en(strobe_en), .strobe_ch(strobe_ch), .phase(phase)
  );

  always_ff @(posedge clk) begin
    if (rst)            dac_code <= '0;
    else if (load_code) dac_code <= rd_data;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) hold_strobe[g] <= 1'b0;
      else     hold_strobe[g] <= strobe_en && (strobe_ch == AW'(g));
    end
  end
endmodule

// File: rtl/sah_refresh_seq_chk.sv
module sah_refresh_seq_chk #(
  parameter int NUM_CH = 32,
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_active,
  input logic              tick,
  input logic [1:0]        phase,
  input logic [NUM_CH-1:0] hold_strobe,
  input logic [CODE_W-1:0] dac_code
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (hold_strobe == '0 && dac_code == '0));

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hold_strobe));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_strobe != '0) |=> (hold_strobe == '0));

  assert_phase_walk_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && phase != 2'd0) |=> (phase == 2'($past(phase) + 2'd1)));

  assert_code_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !(tick && phase == 2'd1) |=> $stable(dac_code));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (cs_active && tick && phase == 2'd0) |=> (phase == 2'd0));
endmodule

bind sah_refresh_seq sah_refresh_seq_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .cs_active(cs_active), .tick(tick), .phase(phase),
  .hold_strobe(hold_strobe), .dac_code(dac_code)
);

// File: tb/sah_refresh_seq_test.sv
module sah_refresh_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 32;
  localparam int CODE_W     = 16;
  localparam int TICK_DIV   = 3;
  localparam int AW         = $clog2(NUM_CH);
  localparam int EV_MAX     = 4096;

  logic clk = 1'b0;
  logic rst, tick_ext_sel, tick_ext_en, cs_active, wr_en, imm_pin, imm_cfg;
  logic [AW-1:0]     wr_addr;
  logic [CODE_W-1:0] wr_code, dac_code;
  logic [NUM_CH-1:0] hold_strobe;

  int checks = 0, errors = 0, cyc = 0, tickc = 0, ev_n = 0, bad_onehot = 0;
  int ev_ch [EV_MAX];
  int ev_code [EV_MAX];
  int ev_cyc [EV_MAX];
  int ev_tick [EV_MAX];
  int code_model [NUM_CH];

  sah_refresh_seq #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .TICK_DIV(TICK_DIV)) uut (
    .clk(clk), .rst(rst), .tick_ext_sel(tick_ext_sel), .tick_ext_en(tick_ext_en),
    .cs_active(cs_active), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .imm_pin(imm_pin), .imm_cfg(imm_cfg), .dac_code(dac_code), .hold_strobe(hold_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: log every strobe a moment after the edge that produced it.
  always @(posedge clk) begin
    cyc++;
    if (tick_ext_sel && tick_ext_en) tickc++;
    #1;
    if (hold_strobe != '0 && ev_n < EV_MAX) begin
      if ($countones(hold_strobe) != 1) bad_onehot++;
      for (int i = 0; i < NUM_CH; i++) if (hold_strobe[i]) ev_ch[ev_n] = i;
      ev_code[ev_n] = int'(dac_code);
      ev_cyc[ev_n]  = cyc;
      ev_tick[ev_n] = tickc;
      ev_n++;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (R1..) actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ev(int n);
    while (ev_n < n) @(negedge clk);
  endtask

  task automatic wait_ch(int c);
    do @(negedge clk); while (!(ev_n > 0 && ev_ch[ev_n-1] == c && ev_cyc[ev_n-1] == cyc));
  endtask

  task automatic put(int a, int c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_code = CODE_W'(c);
    code_model[a] = c & 16'hFFFF;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Coverage of all channels with current codes over events [b, b+n).
  task automatic chk_cover(string req, int b, int n);
    int miss = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      int hit = 0;
      for (int k = b; k < b + n; k++)
        if (ev_ch[k] == c && ev_code[k] == code_model[c]) hit = 1;
      if (!hit) miss++;
    end
    chk(req, miss, 0);
  endtask

  initial begin
    int b, rel, last_a, imm;
    void'($urandom(32'd7919));
    rst = 1'b1; cs_active = 1'b1; tick_ext_sel = 1'b1; tick_ext_en = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_code = '0; imm_pin = 1'b0; imm_cfg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", int'(hold_strobe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset code", int'(dac_code), 0);
    chk("R1 quiet after reset", int'(hold_strobe), 0);

    // Load every channel (burst, scan frozen), then release.
    for (int c = 0; c < NUM_CH; c++) put(c, int'($urandom) & 16'hFFFF);
    @(negedge clk); cs_active = 1'b0;
    b = ev_n;
    wait_ev(b + 64);
    chk("R1 first channel", ev_ch[b], 0);
    for (int i = 0; i < 64; i++) begin
      chk("R3 order", ev_ch[b+i], i % NUM_CH);
      chk("R2 code at strobe", ev_code[b+i], code_model[ev_ch[b+i]]);
      chk("R7 stored code", ev_code[b+i], code_model[i % NUM_CH]);
      if (i > 0) chk("R2 spacing", ev_cyc[b+i] - ev_cyc[b+i-1], 4);
    end
    chk("R3 sweep", ev_tick[b+32] - ev_tick[b], 128);

    // Immediate via pin, interrupt with channel 6 in flight, write channel 20.
    wait_ch(5);
    @(negedge clk);
    cs_active = 1'b1; imm_pin = 1'b1;
    b = ev_n;
    put(20, 16'hA5C3);
    imm_pin = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 frozen count", ev_n - b, 1);
    chk("R6 in-flight finished", ev_ch[b], 6);
    rel = cyc; cs_active = 1'b0;
    wait_ev(b + 4);
    chk("R8 served first", ev_ch[b+1], 20);
    chk("R8 new code", ev_code[b+1], 16'hA5C3);
    chk("R8 latency", (ev_cyc[b+1] - rel <= 8) ? 1 : 0, 1);
    chk("R9 resume", ev_ch[b+2], 6);
    chk("R9 continue", ev_ch[b+3], 7);

    // Immediate via control bit, interrupt while idle after channel 10.
    wait_ch(10);
    cs_active = 1'b1; imm_cfg = 1'b1;
    b = ev_n;
    put(3, 16'h0F0F);
    imm_cfg = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 idle frozen", ev_n - b, 0);
    cs_active = 1'b0;
    wait_ev(b + 3);
    chk("R8 control bit", ev_ch[b], 3);
    chk("R8 control bit code", ev_code[b], 16'h0F0F);
    chk("R9 idle resume", ev_ch[b+1], 11);
    chk("R9 idle continue", ev_ch[b+2], 12);

    // Burst loading with channel 26 in flight.
    wait_ch(25);
    @(negedge clk);
    cs_active = 1'b1;
    put(2, 16'h1111); put(26, 16'h2626); put(30, 16'h3030); put(9, 16'h0909);
    repeat (10) @(negedge clk);
    b = ev_n;
    cs_active = 1'b0;
    wait_ev(b + 32);
    chk("R10 resume first", ev_ch[b], 26);
    chk("R10 resume code", ev_code[b], 16'h2626);
    for (int i = 0; i < 32; i++) chk("R10 order", ev_ch[b+i], (26 + i) % NUM_CH);
    chk_cover("R10 all current", b, 32);

    // Random rounds mixing immediate and burst windows.
    for (int r = 0; r < 6; r++) begin
      int nw;
      repeat (int'($urandom % 8)) @(negedge clk);
      imm = int'($urandom % 2);
      cs_active = 1'b1;
      nw = 1 + int'($urandom % 4);
      last_a = 0;
      for (int w = 0; w < nw; w++) begin
        last_a = int'($urandom % NUM_CH);
        imm_pin = (imm != 0) && ($urandom % 2 == 0);
        imm_cfg = (imm != 0) && !imm_pin;
        put(last_a, int'($urandom) & 16'hFFFF);
      end
      imm_pin = 1'b0; imm_cfg = 1'b0;
      repeat (10) @(negedge clk);
      b = ev_n; rel = cyc;
      cs_active = 1'b0;
      wait_ev(b + 33);
      if (imm != 0) begin
        chk("R8 random served", ev_ch[b], last_a);
        chk("R8 random code", ev_code[b], code_model[last_a]);
        chk("R8 random latency", (ev_cyc[b] - rel <= 8) ? 1 : 0, 1);
      end
      chk_cover("R10 random cover", b, 33);
    end

    // Internal divided tick.
    tick_ext_sel = 1'b0;
    b = ev_n;
    wait_ev(b + 3);
    chk("R5 internal spacing", ev_cyc[b+2] - ev_cyc[b+1], 4 * TICK_DIV);
    // Sparse external enable.
    tick_ext_sel = 1'b1;
    b = ev_n;
    while (ev_n < b + 4) begin
      @(negedge clk);
      tick_ext_en = ($urandom % 3 == 0);
    end
    @(negedge clk); tick_ext_en = 1'b1;
    chk("R5 external ticks", ev_tick[b+2] - ev_tick[b+1], 4);
    chk("R5 external ticks b", ev_tick[b+3] - ev_tick[b+2], 4);

    chk("R4 one-hot strobes", bad_onehot, 0);
    summary();
    $finish;
  end
endmodule